// File: doc/BRIEF.md
# Programmable Output Pin Drive Controller

This block produces the digital enables for one programmable output pad of a power sequencing controller. First it picks the value the pad should carry. There are three choices: the bit coming from the sequencing state machine, a bit that a host writes over the management bus, or a reference clock near 100 kHz. The block makes that clock itself by dividing the system clock.

The chosen value is then combined with a configured drive mode. The result is a set of pad enables: strong pull-down, weak default pull-down, weak pull-up, strong pull-up, pull-up rail select and gate-drive charge pump. Open-drain modes pull the pad low for a 0 and release it for a 1.

Until the configuration has been loaded and marked valid, the pad sees only the weak default pull-down. The high-voltage gate-drive mode exists only on pins numbered 1 to 6. On other pins, a request for that mode behaves as plain open-drain.

Top module: `pdo_drive_ctrl`

## Requirements
- R1: While rst_n is low, and in every cycle after a cycle in which cfg_valid was low, the only asserted output is pd_weak_en.
- R2: src_sel selects the pad value: 0 = seq_data, 1 = host_data, 2 = internal reference clock, 3 = constant 0.
- R3: The reference clock is low for the first DIV_HALF system cycles after reset and then toggles every DIV_HALF cycles, which gives a 50% duty cycle and a period of 2*DIV_HALF cycles.
- R4: In drive_mode 0 (open drain) and in the spare code 7, pd_en equals the inverted value and no pull-up, rail select or charge pump is asserted.
- R5: drive_mode 1 (weak pull-up to core) and drive_mode 3 (weak pull-up to rail) give pu_weak_en = value and pd_en = !value. pu_rail_sel is 1 in mode 3 and 0 in mode 1.
- R6: drive_mode 2 (push-pull to core) and drive_mode 4 (push-pull to rail) give pu_strong_en = value and pd_en = !value. pu_rail_sel is 1 in mode 4 and 0 in mode 2.
- R7: drive_mode 5 asserts pd_en whatever the value is, with no pull-up.
- R8: drive_mode 6 gives cp_en = value and pd_en = !value when PIN_INDEX is 1 to 6. On any other index it behaves as mode 0.
- R9: A pull-up (pu_weak_en, pu_strong_en, cp_en) is never asserted together with pd_en, and at most one pull-up is asserted at a time.
- R10: Outputs are registered: they reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration latched and valid |
| src_sel | input | 2 | Data source select |
| drive_mode | input | 3 | Pad drive mode |
| seq_data | input | 1 | Sequencer output bit |
| host_data | input | 1 | Host-written bit |
| pd_weak_en | output | 1 | Weak default pull-down |
| pd_en | output | 1 | Strong pull-down |
| pu_weak_en | output | 1 | Weak pull-up |
| pu_strong_en | output | 1 | Strong pull-up |
| pu_rail_sel | output | 1 | Pull-up rail: 0 core supply, 1 selected rail |
| cp_en | output | 1 | Charge-pump gate drive |

## Verification
The hardest case to reach is the clock source. The pad value then depends on the divider phase, not on any input, so a check has to agree with the reference clock at every clock edge. The bench counts the edges since reset and works out the phase from R3. It uses a small divisor so that random stimulus falls on both phases many times. A second instance with an index above 6 receives the same stimulus, which checks the gate-drive fallback of R8.

// File: rtl/pdo_drive_ctrl.sv
module pdo_drive_ctrl #(
  parameter int PIN_INDEX = 1,
  parameter int DIV_HALF  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_valid,
  input  logic [1:0] src_sel,
  input  logic [2:0] drive_mode,
  input  logic       seq_data,
  input  logic       host_data,
  output logic       pd_weak_en,
  output logic       pd_en,
  output logic       pu_weak_en,
  output logic       pu_strong_en,
  output logic       pu_rail_sel,
  output logic       cp_en
);

  localparam int CW = $clog2(DIV_HALF + 1);
  localparam bit CP_OK = (PIN_INDEX >= 1) && (PIN_INDEX <= 6);

  localparam logic [2:0] M_OD      = 3'd0;
  localparam logic [2:0] M_WPU_VDD = 3'd1;
  localparam logic [2:0] M_PP_VDD  = 3'd2;
  localparam logic [2:0] M_WPU_RL  = 3'd3;
  localparam logic [2:0] M_PP_RL   = 3'd4;
  localparam logic [2:0] M_PULLDN  = 3'd5;
  localparam logic [2:0] M_CPUMP   = 3'd6;

  logic [CW-1:0] div_cnt;
  logic          ref_clk;
  logic          val;
  logic [2:0]    mode_eff;
  logic [5:0]    nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      ref_clk <= 1'b0;
    end else if (div_cnt == CW'(DIV_HALF - 1)) begin
      div_cnt <= '0;
      ref_clk <= ~ref_clk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_comb begin
    case (src_sel)
      2'd0:    val = seq_data;
      2'd1:    val = host_data;
      2'd2:    val = ref_clk;
      default: val = 1'b0;
    endcase
  end

  assign mode_eff = ((drive_mode == M_CPUMP && !CP_OK) || drive_mode == 3'd7) ? M_OD : drive_mode;

  // nxt = {pd_weak, pd, pu_weak, pu_strong, rail, cp}
  always_comb begin
    nxt = 6'b000000;
    if (!cfg_valid) begin
      nxt[5] = 1'b1;
    end else begin
      case (mode_eff)
        M_WPU_VDD: begin nxt[4] = ~val; nxt[3] = val; end
        M_PP_VDD:  begin nxt[4] = ~val; nxt[2] = val; end
        M_WPU_RL:  begin nxt[4] = ~val; nxt[3] = val; nxt[1] = 1'b1; end
        M_PP_RL:   begin nxt[4] = ~val; nxt[2] = val; nxt[1] = 1'b1; end
        M_PULLDN:  nxt[4] = 1'b1;
        M_CPUMP:   begin nxt[4] = ~val; nxt[0] = val; end
        default:   nxt[4] = ~val;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      {pd_weak_en, pd_en, pu_weak_en, pu_strong_en, pu_rail_sel, cp_en} <= 6'b100000;
    else
      {pd_weak_en, pd_en, pu_weak_en, pu_strong_en, pu_rail_sel, cp_en} <= nxt;
  end

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> !(pu_weak_en || pu_strong_en || cp_en)); // R9
  AST_ONE_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pu_weak_en, pu_strong_en, cp_en})); // R9
  AST_SAFE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> (pd_weak_en && !pd_en && !pu_weak_en && !pu_strong_en && !pu_rail_sel && !cp_en)); // R1
  AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && drive_mode == M_PULLDN) |=> (pd_en && !pu_weak_en && !pu_strong_en)); // R7
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clk) |=> ref_clk); // R3
  AST_RAIL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    pu_rail_sel |-> (pd_en || pu_weak_en || pu_strong_en)); // R5
  AST_CP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cp_en |-> (PIN_INDEX >= 1 && PIN_INDEX <= 6)); // R8

endmodule

// File: tb/pdo_drive_ctrl_test.sv
module pdo_drive_ctrl_test;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [2:0] drive_mode = 3'd0;
  logic seq_data = 1'b0;
  logic host_data = 1'b0;
  logic [5:0] out_lo, out_hi;
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  pdo_drive_ctrl #(.PIN_INDEX(3), .DIV_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .src_sel(src_sel),
    .drive_mode(drive_mode), .seq_data(seq_data), .host_data(host_data),
    .pd_weak_en(out_lo[5]), .pd_en(out_lo[4]), .pu_weak_en(out_lo[3]),
    .pu_strong_en(out_lo[2]), .pu_rail_sel(out_lo[1]), .cp_en(out_lo[0]));

  pdo_drive_ctrl #(.PIN_INDEX(8), .DIV_HALF(HALF)) uut_hi (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .src_sel(src_sel),
    .drive_mode(drive_mode), .seq_data(seq_data), .host_data(host_data),
    .pd_weak_en(out_hi[5]), .pd_en(out_hi[4]), .pu_weak_en(out_hi[3]),
    .pu_strong_en(out_hi[2]), .pu_rail_sel(out_hi[1]), .cp_en(out_hi[0]));

  function automatic logic pick(input logic [1:0] s, input logic sq, input logic hd, input int k);
    case (s)
      2'd0: return sq;
      2'd1: return hd;
      2'd2: return logic'(((k - 1) / HALF) % 2); // R3 phase
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [5:0] expect_out(input logic cv, input logic [2:0] m, input logic d, input bit cp_ok);
    logic [2:0] me;
    me = ((m == 3'd6 && !cp_ok) || m == 3'd7) ? 3'd0 : m;
    if (!cv) return 6'b100000;
    case (me)
      3'd1: return {1'b0, ~d, d, 1'b0, 1'b0, 1'b0};
      3'd2: return {1'b0, ~d, 1'b0, d, 1'b0, 1'b0};
      3'd3: return {1'b0, ~d, d, 1'b0, 1'b1, 1'b0};
      3'd4: return {1'b0, ~d, 1'b0, d, 1'b1, 1'b0};
      3'd5: return 6'b010000;
      3'd6: return {1'b0, ~d, 1'b0, 1'b0, 1'b0, d};
      default: return {1'b0, ~d, 4'b0000};
    endcase
  endfunction

  function automatic string req_of(input logic cv, input logic [2:0] m, input bit cp_ok);
    if (!cv) return "R1";
    case (m)
      3'd1, 3'd3: return "R5";
      3'd2, 3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return cp_ok ? "R8" : "R8 fallback";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic cv, input logic [1:0] s, input logic [2:0] m, input logic sq, input logic hd);
    logic d;
    cfg_valid = cv; src_sel = s; drive_mode = m; seq_data = sq; host_data = hd;
    @(posedge clk);
    @(negedge clk);
    d = pick(s, sq, hd, cyc);
    // R10: sampled one edge after the inputs were applied; R2 source choice
    check($sformatf("%s src=%0d (R2,R10)", req_of(cv, m, 1'b1), s), out_lo, expect_out(cv, m, d, 1'b1));
    check($sformatf("%s src=%0d hi-index (R2,R10)", req_of(cv, m, 1'b0), s), out_hi, expect_out(cv, m, d, 1'b0));
    // R9: exclusivity seen at the ports
    checks++;
    if ((out_lo[4] && (out_lo[3] | out_lo[2] | out_lo[0])) ||
        (int'(out_lo[3]) + int'(out_lo[2]) + int'(out_lo[0]) > 1)) begin
      errors++;
      $display("FAIL R9: actual=%b expected=no pull conflict", out_lo);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    cfg_valid = 1'b1; drive_mode = 3'd2; seq_data = 1'b1;
    @(negedge clk);
    check("R1 in reset", out_lo, 6'b100000);
    rst_n = 1'b1;
    // R1: unconfigured, even with forced-low mode requested
    step(1'b0, 2'd0, 3'd5, 1'b1, 1'b1);
    step(1'b0, 2'd1, 3'd6, 1'b1, 1'b1);
    // R3: clock source held through several full periods in push-pull
    for (int i = 0; i < 4 * HALF; i++) step(1'b1, 2'd2, 3'd2, 1'b0, 1'b0);
    // R8: charge pump on both instances, both data values
    step(1'b1, 2'd1, 3'd6, 1'b0, 1'b1);
    step(1'b1, 2'd1, 3'd6, 1'b0, 1'b0);
    // R2: constant-low source
    step(1'b1, 2'd3, 3'd2, 1'b1, 1'b1);
    // R7 forced low with high data
    step(1'b1, 2'd0, 3'd5, 1'b1, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      logic cv;
      cv = ($urandom % 8) != 0;
      step(cv, 2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule